// File: doc/BRIEF.md
# Chip-Select Address Window Decoder

This block sits between a memory-mapped bus and a set of serial flash devices. It decides which device owns each bus address. Each of the three chip selects has a segment register that holds the low and high bounds of its address window. Both bounds are 8-bit counts of 8 MB units, taken from address bits [30:23]. For every valid bus access the decoder reports one cycle later which chip select owns the address, or that none does. It also reports the byte offset of the address inside the owning window.

Software programs the windows through a small register port. A write strobe, an index and a data word update a register. The register addressed by the index is always visible on a combinational read bus. Two bound fields are fixed because they form the outer edges of the whole aperture: the low bound of chip select 0, which always equals the aperture base, and the high bound of chip select 2.

Top module: `segdec_top`

## Requirements
- R1: After a synchronous active-low reset, the segment registers read 0x60400000 (select 0), 0x54500000 (select 1) and 0x58540000 (select 2). Bits [23:16] of each register are the low bound and bits [31:24] are the high bound.
- R2: The low bound of select 0 always reads 0x40. Writes to that field have no effect on reads or on decoding.
- R3: The high bound of select 2 always reads 0x58. Writes to that field have no effect on reads or on decoding.
- R4: All other bound fields take the written bits [23:16] and [31:24]. Bits [15:0] always read zero. A write whose index is 3 changes no register.
- R5: A select matches when its low bound is less than or equal to address bits [30:23] and those bits are less than its high bound. A window whose low bound is not below its high bound matches nothing. Address bit 31 is not decoded.
- R6: When several windows match, the highest-numbered select wins. The chip-select output is one-hot, with bit n meaning select n.
- R7: When no window matches a valid access, the miss flag is set and the chip-select output is zero.
- R8: The offset equals address bits [30:0] minus the winning low bound shifted left by 23. On a miss the offset is zero.
- R9: The response appears exactly one cycle after the access. In a cycle with no access, the response-valid flag, chip select, miss flag and offset are all zero.
- R10: An access made in the same cycle as a register write is decoded with the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_addr | input | 32 | Bus byte address |
| reg_wr | input | 1 | Segment register write strobe |
| reg_idx | input | 2 | Segment register index, used for both write and read |
| reg_wdata | input | 32 | Segment register write data |
| reg_rdata | output | 32 | Contents of the indexed segment register |
| rsp_valid | output | 1 | Decode result valid |
| rsp_cs | output | 3 | One-hot owning chip select |
| rsp_miss | output | 1 | No window matched |
| rsp_offset | output | 31 | Byte offset inside the owning window |

## Verification
A corrupted bound field would first show on the read port in the same cycle the register is indexed. On the decode outputs it would show one cycle after the first access that falls near the affected boundary. Because of this, accesses are placed at both edges of every window and just outside them. A wrong priority order or offset base would only appear for addresses in overlapping windows. The bench therefore checks overlap regions and compares every cycle against the model, using random register contents.

// File: rtl/segdec_pkg.sv
// Package: shared constants, the bound-pair type and reset-default lookups
// for the chip-select window decoder. Assumes the bounds use 8 MB units.
package segdec_pkg;

    localparam int FIELD_W  = 8;
    localparam int UNIT_LSB = 23;

    typedef logic [FIELD_W-1:0] unit_t;

    // Packed so that lim lands in [31:24] and base in [23:16] when shifted up.
    typedef struct packed {
        unit_t lim;
        unit_t base;
    } seg_t;

    // Reset low bound per chip select.
    function automatic unit_t dflt_base(input int idx);
        case (idx)
            0:       return 8'h40;
            1:       return 8'h50;
            2:       return 8'h54;
            default: return 8'h00;
        endcase
    endfunction

    // Reset high bound per chip select.
    function automatic unit_t dflt_lim(input int idx);
        case (idx)
            0:       return 8'h60;
            1:       return 8'h54;
            2:       return 8'h58;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/segdec_regfile.sv
// Segment register file. Holds one low/high bound pair per chip select.
// The low bound of select 0 and the high bound of the last select are
// constants. Writes to index values at or above NUM_CS touch nothing.
// The register named by idx is presented combinationally on rdata.
module segdec_regfile
    import segdec_pkg::*;
#(
    parameter int NUM_CS = 3,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [IDX_W-1:0]      idx,
    input  logic [DATA_W-1:0]     wdata,
    output seg_t [NUM_CS-1:0]     segs,
    output logic [DATA_W-1:0]     rdata
);

    localparam int BASE_LSB = 16;
    localparam int LIM_LSB  = BASE_LSB + FIELD_W;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_seg
        logic sel_w;
        assign sel_w = wr && (idx == IDX_W'(i));

        if (i == 0) begin : g_base_fixed
            assign segs[i].base = dflt_base(i);
        end else begin : g_base_rw
            unit_t base_q;
            // Programmable low bound with reset default.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    base_q <= dflt_base(i);
                else if (sel_w)
                    base_q <= wdata[BASE_LSB +: FIELD_W];
            end
            assign segs[i].base = base_q;
        end

        if (i == NUM_CS - 1) begin : g_lim_fixed
            assign segs[i].lim = dflt_lim(i);
        end else begin : g_lim_rw
            unit_t lim_q;
            // Programmable high bound with reset default.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    lim_q <= dflt_lim(i);
                else if (sel_w)
                    lim_q <= wdata[LIM_LSB +: FIELD_W];
            end
            assign segs[i].lim = lim_q;
        end
    end

    // Read mux: indexed bound pair in the upper half, reserved bits zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (idx == IDX_W'(i))
                rdata[BASE_LSB +: 2*FIELD_W] = segs[i];
        end
    end

endmodule

// File: rtl/segdec_match.sv
// Window comparators. One half-open range test per chip select on the
// 8 MB unit index taken from the address. Address bits above the unit
// field are not looked at.
module segdec_match
    import segdec_pkg::*;
#(
    parameter int NUM_CS = 3,
    parameter int ADDR_W = 32
) (
    input  seg_t [NUM_CS-1:0]  segs,
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_CS-1:0]  hit
);

    unit_t unit;
    assign unit = addr[UNIT_LSB +: FIELD_W];

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cmp
        // Low bound inclusive, high bound exclusive.
        assign hit[i] = (unit >= segs[i].base) && (unit < segs[i].lim);
    end

endmodule

// File: rtl/segdec_pick.sv
// Priority pick. The highest-numbered matching select wins. Produces the
// one-hot select, the miss flag and the offset from the winning low bound.
module segdec_pick
    import segdec_pkg::*;
#(
    parameter int NUM_CS = 3,
    parameter int ADDR_W = 32,
    parameter int OFF_W  = UNIT_LSB + FIELD_W
) (
    input  seg_t [NUM_CS-1:0]  segs,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_CS-1:0]  hit,
    output logic [NUM_CS-1:0]  sel,
    output logic               miss,
    output logic [OFF_W-1:0]   offset
);

    unit_t win_base;
    unit_t unit;
    assign unit = addr[UNIT_LSB +: FIELD_W];

    // Ascending scan; later matches overwrite earlier ones.
    always_comb begin
        sel      = '0;
        win_base = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (hit[i]) begin
                sel      = '0;
                sel[i]   = 1'b1;
                win_base = segs[i].base;
            end
        end
    end

    assign miss = (hit == '0);

    // Offset: unit difference above the in-unit byte bits; zero on a miss.
    always_comb begin
        if (miss)
            offset = '0;
        else
            offset = {unit - win_base, addr[UNIT_LSB-1:0]};
    end

endmodule

// File: rtl/segdec_top.sv
// Chip-select address window decoder top. Register port programs the
// windows. Each valid access is decoded with the current window settings
// and the result is registered, so it appears one cycle later.
// Assumes a synchronous active-low reset and three or more selects.
module segdec_top
    import segdec_pkg::*;
#(
    parameter int NUM_CS = 3,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(NUM_CS),
    localparam int OFF_W = UNIT_LSB + FIELD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               reg_wr,
    input  logic [IDX_W-1:0]   reg_idx,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               rsp_valid,
    output logic [NUM_CS-1:0]  rsp_cs,
    output logic               rsp_miss,
    output logic [OFF_W-1:0]   rsp_offset
);

    seg_t [NUM_CS-1:0] segs;
    logic [NUM_CS-1:0] hit;
    logic [NUM_CS-1:0] sel;
    logic              miss;
    logic [OFF_W-1:0]  offset;

    segdec_regfile #(
        .NUM_CS (NUM_CS),
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .idx   (reg_idx),
        .wdata (reg_wdata),
        .segs  (segs),
        .rdata (reg_rdata)
    );

    segdec_match #(
        .NUM_CS (NUM_CS),
        .ADDR_W (ADDR_W)
    ) u_match (
        .segs (segs),
        .addr (bus_addr),
        .hit  (hit)
    );

    segdec_pick #(
        .NUM_CS (NUM_CS),
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) u_pick (
        .segs   (segs),
        .addr   (bus_addr),
        .hit    (hit),
        .sel    (sel),
        .miss   (miss),
        .offset (offset)
    );

    // Response register; everything clears when no access is present.
    always_ff @(posedge clk) begin
        if (!rst_n || !bus_valid) begin
            rsp_valid  <= 1'b0;
            rsp_cs     <= '0;
            rsp_miss   <= 1'b0;
            rsp_offset <= '0;
        end else begin
            rsp_valid  <= 1'b1;
            rsp_cs     <= sel;
            rsp_miss   <= miss;
            rsp_offset <= offset;
        end
    end

endmodule

// File: rtl/segdec_chk.sv
// Checker for segdec_top: port-level properties of the decode response
// and the fixed register fields. Attached by bind below.
module segdec_chk
    import segdec_pkg::*;
#(
    parameter int NUM_CS = 3,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 31
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_valid,
    input logic [IDX_W-1:0]   reg_idx,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic               rsp_valid,
    input logic [NUM_CS-1:0]  rsp_cs,
    input logic               rsp_miss,
    input logic [OFF_W-1:0]   rsp_offset
);

    // R6: at most one select reported.
    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_cs));

    // R7: every valid response is either a hit or a miss, never both.
    p_hit_xor_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_miss != (rsp_cs != '0)));

    // R8: a miss carries a zero offset.
    p_miss_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss) |-> (rsp_offset == '0));

    // R9: an access yields a response on the next cycle.
    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> rsp_valid);

    // R9: no access gives an all-zero response on the next cycle.
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> (!rsp_valid && rsp_cs == '0 && !rsp_miss && rsp_offset == '0));

    // R2: select 0 low bound reads fixed.
    p_ce0_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == IDX_W'(0)) |-> (reg_rdata[23:16] == dflt_base(0)));

    // R3: last select high bound reads fixed.
    p_last_lim_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == IDX_W'(NUM_CS-1)) |-> (reg_rdata[31:24] == dflt_lim(NUM_CS-1)));

    // R4: reserved low half reads zero.
    p_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[15:0] == 16'h0);

endmodule

bind segdec_top segdec_chk #(
    .NUM_CS (NUM_CS),
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W),
    .OFF_W  (OFF_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .reg_idx    (reg_idx),
    .reg_rdata  (reg_rdata),
    .rsp_valid  (rsp_valid),
    .rsp_cs     (rsp_cs),
    .rsp_miss   (rsp_miss),
    .rsp_offset (rsp_offset)
);

// File: tb/tb_segdec_top.sv
`timescale 1ns/1ps
// Bench: behavioural model of the windows, compared every cycle.
module tb_segdec_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rsp_valid;
    logic [2:0]  rsp_cs;
    logic        rsp_miss;
    logic [30:0] rsp_offset;

    always #2 clk = ~clk;

    segdec_top dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rsp_valid(rsp_valid), .rsp_cs(rsp_cs),
        .rsp_miss(rsp_miss), .rsp_offset(rsp_offset)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int mb[3];
    int ml[3];
    logic        e_valid;
    logic [2:0]  e_cs;
    logic        e_miss;
    logic [30:0] e_off;
    string       e_tag;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        mb[0] = 'h40; ml[0] = 'h60;
        mb[1] = 'h50; ml[1] = 'h54;
        mb[2] = 'h54; ml[2] = 'h58;
        e_valid = 0; e_cs = 0; e_miss = 0; e_off = 0; e_tag = "R9";
    endtask

    // One cycle: check last response, drive new inputs, check read port, predict.
    task automatic step(input string tag, input bit v, input logic [31:0] a,
                        input bit w, input logic [1:0] idx, input logic [31:0] d);
        int unit, win;
        logic [31:0] exp_rd;
        @(negedge clk);
        chk(e_tag, "rsp_valid", 32'(rsp_valid), 32'(e_valid));
        chk(e_tag, "rsp_cs", 32'(rsp_cs), 32'(e_cs));
        chk(e_tag, "rsp_miss", 32'(rsp_miss), 32'(e_miss));
        chk(e_tag, "rsp_offset", 32'(rsp_offset), 32'(e_off));
        bus_valid = v; bus_addr = a; reg_wr = w; reg_idx = idx; reg_wdata = d;
        #1;
        exp_rd = (idx < 3) ? ((32'(ml[idx]) << 24) | (32'(mb[idx]) << 16)) : 32'h0;
        chk(tag, "reg_rdata", reg_rdata, exp_rd);
        unit = int'(a[30:23]);
        win = -1;
        for (int i = 0; i < 3; i++)
            if (unit >= mb[i] && unit < ml[i]) win = i;
        e_tag = tag;
        e_valid = v;
        e_cs = (v && win >= 0) ? 3'(1 << win) : 3'b000;
        e_miss = v && (win < 0);
        e_off = (v && win >= 0) ? 31'(((unit - mb[win]) << 23) | int'(a[22:0])) : 31'h0;
        if (w && idx < 3) begin
            if (idx != 0) mb[idx] = int'(d[23:16]);
            if (idx != 2) ml[idx] = int'(d[31:24]);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset register contents, idle outputs (R9).
        step("R1", 0, 0, 0, 2'd0, 0);
        step("R1", 0, 0, 0, 2'd1, 0);
        step("R1", 0, 0, 0, 2'd2, 0);
        // R5/R6/R8: default windows, edges and overlaps.
        step("R5", 1, 32'h2000_0000, 0, 2'd0, 0);
        step("R6", 1, 32'h2800_0000, 0, 2'd1, 0);
        step("R8", 1, 32'h29FF_FFFF, 0, 2'd2, 0);
        step("R6", 1, 32'h2A00_0000, 0, 2'd0, 0);
        step("R8", 1, 32'h2BFF_FFFF, 0, 2'd0, 0);
        step("R8", 1, 32'h2C00_0000, 0, 2'd0, 0);
        step("R5", 1, 32'h2FFF_FFFF, 0, 2'd0, 0);
        // R7: outside every window.
        step("R7", 1, 32'h3000_0000, 0, 2'd0, 0);
        step("R7", 1, 32'h1FFF_FFFF, 0, 2'd0, 0);
        // R5: bit 31 not decoded.
        step("R5", 1, 32'hA800_0004, 0, 2'd0, 0);
        step("R9", 0, 32'h2800_0000, 0, 2'd0, 0);
        // R2: select 0 low bound fixed, high bound writable.
        step("R2", 0, 0, 1, 2'd0, 32'hFFFF_1234);
        step("R2", 1, 32'h7F80_0000, 0, 2'd0, 0);
        step("R2", 1, 32'h1F80_0000, 0, 2'd0, 0);
        // R3: last high bound fixed, low bound writable; overlap priority R6.
        step("R3", 0, 0, 1, 2'd2, 32'h0010_0000);
        step("R3", 1, 32'h2BFF_FFFF, 0, 2'd2, 0);
        step("R6", 1, 32'h2800_0000, 0, 2'd2, 0);
        step("R3", 1, 32'h2C00_0000, 0, 2'd2, 0);
        // R4: index 3 writes nothing.
        step("R4", 0, 0, 1, 2'd3, 32'hFFFF_FFFF);
        step("R4", 0, 0, 0, 2'd0, 0);
        step("R4", 0, 0, 0, 2'd1, 0);
        step("R4", 0, 0, 0, 2'd2, 0);
        // R10: write select 2 while decoding with the old window.
        step("R10", 1, 32'h2000_0000, 1, 2'd2, 32'h0060_0000);
        step("R10", 1, 32'h2000_0000, 0, 2'd2, 0);
        // R5: empty window (low bound not below high bound).
        step("R5", 0, 0, 1, 2'd1, 32'h5050_0000);
        step("R5", 1, 32'h2800_0000, 0, 2'd1, 0);
        // Random coverage of all rules.
        for (int n = 0; n < 400; n++) begin
            logic [31:0] ra;
            logic [31:0] rd;
            ra = $urandom;
            rd = $urandom;
            if (n % 3 == 0) ra[30:23] = 8'h38 + 8'($urandom_range(0, 47));
            step("R5", ($urandom_range(0, 3) != 0), ra, ($urandom_range(0, 7) == 0),
                 2'($urandom_range(0, 3)), rd);
        end
        step("R9", 0, 0, 0, 2'd0, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule